// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Burst SRAM

This block is a synchronous static memory with registered control inputs and a flow-through read path. Each word is 36 bits wide and is split into four 9-bit byte lanes, and the depth is set by a parameter. Every control input is sampled on the rising clock edge. An active-low clock enable qualifies each edge. When the clock enable is held high, the edge is stalled, and this is the only way to hold the block back. There is no valid/ready handshake, because every transfer completes on a fixed clock edge.

A write presents its address on one enabled edge and its data on the next enabled edge. Because of this, reads and writes can alternate on every cycle with no idle cycle between them. A single load/advance input chooses between two actions: it either registers a new address, or it steps a 2-bit burst counter. A strap input sets the counter order to linear or interleaved. The shared data bus is modelled as three ports: a write-data input, a read-data output and an output-enable flag. The block drives that output-enable flag low by itself during write data cycles and while it is deselected.

Top module: `zbt_flow_sram`

## Requirements
- R1: When `clk_en_n` is 1 on an edge, that edge is ignored. The address, the access state and the memory contents are unchanged, `rdata` and `rdata_oe` hold their values, and the device stays selected.
- R2: On an enabled edge with `load_n`=0, the device is selected only if `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. If any one of the three is inactive, the device is deselected and `rdata_oe` is 0 after that edge.
- R3: On an enabled edge with `load_n`=0 and the device selected, `addr` is registered. `write_n`=0 starts a write and `write_n`=1 starts a read. That access type is kept for every advance cycle that follows.
- R4: On an enabled edge with `load_n`=1 during an active access, only the low two address bits step. The selects and `write_n` are ignored, the sequence returns to the start after four beats, and bits above bit 1 never change.
- R5: With `burst_xor`=0, beat i uses low bits (start+i) mod 4. With `burst_xor`=1, beat i uses start XOR i.
- R6: For a write registered on one enabled edge, the data is captured from `wdata` on the next enabled edge. A new read, write or deselect can be registered on that same edge.
- R7: When `lane_we_n[i]`=0, the write data cycle stores `wdata[9i+8:9i]`. Lanes whose bit is 1 keep their stored value.
- R8: A read returns the addressed word on `rdata` directly after the edge that registered or advanced its address, with no extra register stage. A read registered on the data edge of a write to the same address returns the newly merged word.
- R9: `rdata_oe` is 1 only while a read access is registered and `drive_n`=0. It is 0 during write data cycles. `drive_n`=1 forces it to 0 at once, without waiting for a clock edge.
- R10: During and after reset, the device is deselected and `rdata_oe` is 0.
- R11: While the device is deselected, an enabled edge with `load_n`=1 starts no access, and `rdata_oe` stays 0 until a new address is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; 1 stalls the edge |
| sel_a_n | input | 1 | Active-low chip select A |
| sel_b | input | 1 | Active-high chip select B |
| sel_c_n | input | 1 | Active-low chip select C |
| load_n | input | 1 | 0 loads a new address, 1 advances the burst |
| write_n | input | 1 | 0 selects a write on a load edge |
| lane_we_n | input | LANES | Active-low write select for each byte lane |
| addr | input | ADDR_W | Word address |
| burst_xor | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| drive_n | input | 1 | Asynchronous active-low output enable |
| wdata | input | LANES*LANE_W | Write data, captured on the data edge |
| rdata | output | LANES*LANE_W | Flow-through read data |
| rdata_oe | output | 1 | 1 when the block drives the data bus |

## Verification
Read data and its enable are due in the same cycle as the edge that registers or advances the read address. The bench therefore samples 5 ns after that edge and before it drives the next inputs. Write data is captured one enabled edge after the write address. Each write is checked by a read that is registered on that very data edge, and then by reads during a later burst. The `drive_n` path has no register, so it is sampled 1 ns after the input toggles. A stalled edge is checked by comparing the outputs one full cycle later against the values they had before the stall.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_WR   = 2'd2
  } acc_e;
endpackage

// File: rtl/zbt_burst_seq.sv
module zbt_burst_seq #(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] start_lo,
  input  logic [CNT_W-1:0] beat,
  input  logic             xor_mode,
  output logic [CNT_W-1:0] lo
);
  // Low address bits for the current beat; wraps inside CNT_W bits.
  always_comb begin
    if (xor_mode) lo = start_lo ^ beat;
    else          lo = start_lo + beat;
  end
endmodule

// File: rtl/zbt_ctrl.sv
module zbt_ctrl
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              load_n,
  input  logic              sel_ok,
  input  logic              write_n,
  input  logic              burst_xor,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] cur_addr,
  output acc_e              acc
);
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  beat_q;
  logic [CNT_W-1:0]  lo;
  acc_e              acc_q;

  zbt_burst_seq #(.CNT_W(CNT_W)) u_seq (
    .start_lo (base_q[CNT_W-1:0]),
    .beat     (beat_q),
    .xor_mode (burst_xor),
    .lo       (lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
      acc_q  <= ACC_IDLE;
    end else if (step_en) begin
      if (!load_n) begin
        base_q <= addr;
        beat_q <= '0;
        if (!sel_ok)       acc_q <= ACC_IDLE;
        else if (!write_n) acc_q <= ACC_WR;
        else               acc_q <= ACC_RD;
      end else if (acc_q != ACC_IDLE) begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  assign cur_addr = {base_q[ADDR_W-1:CNT_W], lo};
  assign acc      = acc_q;
endmodule

// File: rtl/zbt_lane_store.sv
module zbt_lane_store #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/zbt_flow_sram.sv
module zbt_flow_sram
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    load_n,
  input  logic                    write_n,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    burst_xor,
  input  logic                    drive_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_oe
);
  localparam int CNT_W = 2;

  logic              step_en;
  logic              sel_ok;
  logic              commit;
  logic [ADDR_W-1:0] cur_addr;
  acc_e              acc;

  assign step_en = ~clk_en_n;
  assign sel_ok  = ~sel_a_n & sel_b & ~sel_c_n;

  zbt_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .load_n    (load_n),
    .sel_ok    (sel_ok),
    .write_n   (write_n),
    .burst_xor (burst_xor),
    .addr      (addr),
    .cur_addr  (cur_addr),
    .acc       (acc)
  );

  // The data phase of the registered write lands on the next enabled edge.
  assign commit = step_en & (acc == ACC_WR);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    zbt_lane_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
      .clk   (clk),
      .we    (commit & ~lane_we_n[g]),
      .addr  (cur_addr),
      .wdata (wdata[g*LANE_W +: LANE_W]),
      .rdata (rdata[g*LANE_W +: LANE_W])
    );
  end

  assign rdata_oe = (acc == ACC_RD) & ~drive_n;
endmodule

// File: rtl/zbt_flow_sram_chk.sv
module zbt_flow_sram_chk
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en_n,
  input logic              sel_a_n,
  input logic              sel_b,
  input logic              sel_c_n,
  input logic              load_n,
  input logic              write_n,
  input logic              drive_n,
  input logic              rdata_oe,
  input logic [ADDR_W-1:0] cur_addr,
  input acc_e              acc
);
  logic sel_all;
  assign sel_all = ~sel_a_n & sel_b & ~sel_c_n;

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(cur_addr) && $stable(acc)));

  // R2
  desel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !load_n && !sel_all) |=> !rdata_oe);

  // R9
  wdata_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !load_n && sel_all && !write_n) |=> !rdata_oe);

  // R4
  adv_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && load_n && acc != ACC_IDLE)
      |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));

  // R3
  adv_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && load_n) |=> (acc == $past(acc)));

  // R11
  idle_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && load_n && acc == ACC_IDLE) |=> (acc == ACC_IDLE));

  // R9
  drive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_n |-> !rdata_oe);
endmodule

bind zbt_flow_sram zbt_flow_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clk_en_n (clk_en_n),
  .sel_a_n  (sel_a_n),
  .sel_b    (sel_b),
  .sel_c_n  (sel_c_n),
  .load_n   (load_n),
  .write_n  (write_n),
  .drive_n  (drive_n),
  .rdata_oe (rdata_oe),
  .cur_addr (cur_addr),
  .acc      (acc)
);

// File: tb/tb_zbt_flow_sram.sv
module tb_zbt_flow_sram;
  localparam int AW = 8;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DW = LN * LW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, clk_en_n, sel_a_n, sel_b, sel_c_n, load_n, write_n;
  logic          burst_xor, drive_n, rdata_oe;
  logic [LN-1:0] lane_we_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;

  int n_chk  = 0;
  int n_fail = 0;
  logic [DW-1:0] refm [0:(1<<AW)-1];

  zbt_flow_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel_a_n(sel_a_n),
    .sel_b(sel_b), .sel_c_n(sel_c_n), .load_n(load_n), .write_n(write_n),
    .lane_we_n(lane_we_n), .addr(addr), .burst_xor(burst_xor),
    .drive_n(drive_n), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic sel_on();
    sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
  endtask

  task automatic idle_in();
    clk_en_n = 1'b0; load_n = 1'b0; write_n = 1'b1;
    sel_a_n = 1'b1; sel_b = 1'b1; sel_c_n = 1'b0;
    lane_we_n = '1; addr = '0; wdata = '0;
  endtask

  function automatic logic [DW-1:0] pat(input logic [7:0] a, input logic [3:0] k);
    return {k, a, ~a, a ^ 8'h5A, k, ~k};
  endfunction

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] s, input int i, input bit x);
    logic [1:0] b;
    logic [1:0] lo;
    b  = i[1:0];
    lo = x ? (s[1:0] ^ b) : (s[1:0] + b);
    return {s[AW-1:2], lo};
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; drive_n = 1'b0; burst_xor = 1'b0;
    idle_in();
    repeat (3) tick();
    chk("R10 oe in reset", {35'd0, rdata_oe}, 36'd0);
    rst_n = 1'b1;
    load_n = 1'b1; sel_on();
    tick();
    chk("R10 oe after reset", {35'd0, rdata_oe}, 36'd0);
    idle_in();
  endtask

  task automatic t_burst(input bit x, input logic [AW-1:0] s, input logic [3:0] k);
    burst_xor = x;
    sel_on(); load_n = 1'b0; write_n = 1'b0; addr = s;
    tick();
    chk("R9 oe off in write data cycle", {35'd0, rdata_oe}, 36'd0);
    for (int i = 0; i < 4; i++) begin
      wdata = pat(beat_addr(s, i, x), k); lane_we_n = '0;
      if (i < 3) begin
        load_n = 1'b1; sel_a_n = 1'b1; sel_b = 1'b0; write_n = 1'b1; addr = ~s;
      end else begin
        sel_on(); load_n = 1'b0; write_n = 1'b1; addr = s;
      end
      tick();
      refm[beat_addr(s, i, x)] = pat(beat_addr(s, i, x), k);
      if (i < 3) chk("R4 write burst ignores selects", {35'd0, rdata_oe}, 36'd0);
    end
    lane_we_n = '1;
    chk("R8 read on data edge", rdata, refm[s]);
    chk("R6 read follows write with no gap", {35'd0, rdata_oe}, 36'd1);
    for (int i = 1; i < 5; i++) begin
      load_n = 1'b1; sel_a_n = 1'b1; write_n = 1'b0; addr = ~s;
      tick();
      chk(x ? "R5 interleaved beat" : "R5 linear beat", rdata, refm[beat_addr(s, i, x)]);
      chk("R3 read type kept", {35'd0, rdata_oe}, 36'd1);
    end
    chk("R4 wrap to start", rdata, refm[s]);
    idle_in();
    tick();
  endtask

  task automatic t_bytes();
    logic [DW-1:0] a_w, b_w, exp_w;
    a_w = pat(8'h50, 4'h3); b_w = pat(8'hAF, 4'hC);
    sel_on(); load_n = 1'b0; write_n = 1'b0; addr = 8'h50;
    tick();
    wdata = a_w; lane_we_n = 4'b0000;
    tick();
    wdata = b_w; lane_we_n = 4'b1010; write_n = 1'b1;
    tick();
    exp_w = a_w;
    exp_w[0*LW +: LW] = b_w[0*LW +: LW];
    exp_w[2*LW +: LW] = b_w[2*LW +: LW];
    refm[8'h50] = exp_w;
    chk("R7 lane merge", rdata, exp_w);
    idle_in();
    tick();
  endtask

  task automatic t_stall();
    logic [DW-1:0] good;
    good = pat(8'h60, 4'h9);
    sel_on(); load_n = 1'b0; write_n = 1'b0; addr = 8'h60;
    tick();
    clk_en_n = 1'b1; wdata = ~good; lane_we_n = '0; addr = 8'h61; write_n = 1'b1;
    tick();
    tick();
    chk("R1 stalled write data cycle", {35'd0, rdata_oe}, 36'd0);
    clk_en_n = 1'b0; wdata = good; addr = 8'h60;
    tick();
    refm[8'h60] = good;
    chk("R1 stalled edge wrote nothing", rdata, good);
    lane_we_n = '1;
    clk_en_n = 1'b1; load_n = 1'b0; sel_b = 1'b0; addr = 8'h50;
    tick();
    chk("R1 stall keeps read data", rdata, good);
    chk("R1 stall is not a deselect", {35'd0, rdata_oe}, 36'd1);
    idle_in();
    tick();
  endtask

  task automatic t_deselect();
    for (int j = 0; j < 3; j++) begin
      sel_on(); load_n = 1'b0; write_n = 1'b1; addr = 8'h60;
      tick();
      chk("R2 selected read", {35'd0, rdata_oe}, 36'd1);
      if (j == 0) sel_a_n = 1'b1;
      else if (j == 1) sel_b = 1'b0;
      else sel_c_n = 1'b1;
      tick();
      chk("R2 one select deselects", {35'd0, rdata_oe}, 36'd0);
    end
    sel_on(); load_n = 1'b1; write_n = 1'b1;
    tick();
    tick();
    chk("R11 advance while deselected", {35'd0, rdata_oe}, 36'd0);
    load_n = 1'b0; addr = 8'h60;
    tick();
    chk("R11 reload resumes read", rdata, refm[8'h60]);
    idle_in();
    tick();
  endtask

  task automatic t_drive();
    sel_on(); load_n = 1'b0; write_n = 1'b1; addr = 8'h50;
    tick();
    chk("R9 read drives bus", {35'd0, rdata_oe}, 36'd1);
    drive_n = 1'b1;
    #1;
    chk("R9 drive_n forces off", {35'd0, rdata_oe}, 36'd0);
    drive_n = 1'b0;
    #1;
    chk("R9 drive_n released", {35'd0, rdata_oe}, 36'd1);
    idle_in();
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_burst(1'b0, 8'h21, 4'h1);
    t_burst(1'b1, 8'h45, 4'h2);
    t_burst(1'b0, 8'h33, 4'h4);
    t_bytes();
    t_stall();
    t_deselect();
    t_drive();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule